// File: doc/BRIEF.md
# Shared-Bus Serial Register Port

This block is the serial command front end of a segment display driver. Two copies of the driver can sit on one serial bus, sharing clock, data-in, data-out and one active-low enable line. A strap input gives each copy its chip number. A frame starts with a five-bit header. The header carries a read flag, a one-bit chip number, a two-bit register number and a spare bit. Next comes a data/command flag and a 24-bit word, most significant bit first. Any number of frames may follow one another while the enable stays low. Each frame carries its own header.

The serial pins are oversampled in the system clock domain. Each pin passes through a two-stage synchroniser, and SCLK edges are detected from the synchronised copy. A completed data frame writes one of four 24-bit registers, which drive the rest of the chip. A completed command frame gives a one-cycle command strobe. A read frame returns the addressed register on MISO. Register 3 holds a two-bit lock field in bits [1:0]. The code 2'b11 freezes all writes and commands until a write to register 3 puts a different code in that field.

The frame sequencer has four named states:
- IDLE: the enable is high.
- HEADER: header bits are being collected.
- PAYLOAD: the flag and word of an addressed frame are being collected.
- IGNORE: the frame named another chip, so the rest of the transaction is dropped.

The transitions are:
- IDLE to HEADER when the enable falls.
- HEADER to PAYLOAD on the last header bit when the chip number matches.
- HEADER to IGNORE on the last header bit when the chip number does not match.
- PAYLOAD to HEADER on the last payload bit.
- Every state returns to IDLE when the enable rises.

Top module: `mdspi_regif`

## Requirements
- R1: After reset all four registers read zero, MISO is 0, `locked` is 0 and `cmd_valid` is 0.
- R2: A frame has 30 bits, sampled on rising SCLK in this order: read flag (1 = read), chip number, register number MSB first, spare bit, data/command flag (1 = data), then 24 data bits MSB first. A data write to a matching chip stores the word in the named register.
- R3: If the chip number differs from `chip_id`, that frame and every later frame before the enable rises change nothing, and MISO stays 0 until the enable rises.
- R4: Several complete frames under one enable-low period are each decoded from their own header.
- R5: In a read frame MISO is 0 during the header and flag bits. After the falling SCLK edge that follows the flag bit, MISO presents register bit 23, then one lower bit after each later falling edge, down to bit 0. After that MISO returns to 0. MISO changes only after a falling SCLK edge or when the enable goes high.
- R6: When register 3 bits [1:0] equal 2'b11, `locked` is 1 and every data write and command is ignored. The one exception is a data write to register 3 whose bits [1:0] are not 2'b11: it is stored in full and clears the lock.
- R7: Lock field codes 2'b00, 2'b01 and 2'b10 leave all writes and commands enabled.
- R8: Raising the enable in mid-frame discards the partial frame. The next frame is decoded from its first bit.
- R9: A frame with flag 0 leaves the registers unchanged and gives a one-cycle `cmd_valid` pulse with the 24-bit word on `cmd_data`.
- R10: The value of the spare header bit has no effect.
- R11: Reads return register contents while locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_cs_n | input | 1 | Active-low enable |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out, 0 when not driving read data |
| chip_id | input | CHIP_W | Strap selecting the chip number this copy answers |
| cfg_regs | output | 4*DATA_W | Register contents, register i at bits [i*DATA_W +: DATA_W] |
| locked | output | 1 | Lock field of register 3 holds 2'b11 |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_data | output | DATA_W | Word of the last command |

## Verification
Every pin change passes two synchroniser stages before the sequencer sees it. MISO therefore moves on the third system edge after the pin change. Register contents, `locked` and the command strobe move on the fourth edge, because the write strobe adds one more register. The bench holds each SCLK level for eight system clocks and counts the edges since its last pin change. It compares its model with the registers, `locked` and MISO on every clock from the fifth edge on, so each result is checked only once it is due. Read words are captured just before the rising SCLK edge that would sample them, and command counts are checked once the frame has settled.

// File: rtl/mdspi_pkg.sv
`timescale 1ns/1ps
package mdspi_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_HEADER  = 2'd1,
        ST_PAYLOAD = 2'd2,
        ST_IGNORE  = 2'd3
    } frm_state_e;

    localparam logic [1:0] LOCK_CODE = 2'b11;
endpackage

// File: rtl/mdspi_sync.sv
`timescale 1ns/1ps
module mdspi_sync #(
    parameter int           W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q_out  <= RST_VAL;
        end else begin
            meta_q <= d_in;
            q_out  <= meta_q;
        end
    end
endmodule

// File: rtl/mdspi_frame.sv
`timescale 1ns/1ps
module mdspi_frame
    import mdspi_pkg::*;
#(
    parameter int CHIP_W = 1,
    parameter int REG_AW = 2,
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              si,
    input  logic [CHIP_W-1:0] chip_id,
    input  logic [DATA_W-1:0] rd_data,
    output logic [REG_AW-1:0] rd_addr,
    output logic              wr_stb,
    output logic              wr_dc,
    output logic [REG_AW-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              so,
    output frm_state_e        state_o
);
    localparam int HDR_W = 1 + CHIP_W + REG_AW + 1;
    localparam int PAY_W = DATA_W + 1;
    localparam int CNT_W = $clog2(PAY_W + 1);
    localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(HDR_W - 1);
    localparam logic [CNT_W-1:0] PAY_LAST = CNT_W'(PAY_W - 1);

    frm_state_e          state_q, state_d;
    logic [CNT_W-1:0]    cnt_q;
    logic [HDR_W-2:0]    hdr_sr;
    logic [DATA_W-1:0]   pay_sr;
    logic [DATA_W-1:0]   so_sr;
    logic                rw_q;
    logic [REG_AW-1:0]   reg_q;

    logic [HDR_W-1:0]    hdr_full;
    logic [PAY_W-1:0]    pay_full;
    logic                hdr_last, pay_last, chip_hit;

    assign hdr_full = {hdr_sr, si};
    assign pay_full = {pay_sr, si};
    assign hdr_last = (cnt_q == HDR_LAST);
    assign pay_last = (cnt_q == PAY_LAST);
    assign chip_hit = (hdr_full[HDR_W-2 -: CHIP_W] == chip_id);
    assign rd_addr  = hdr_full[REG_AW:1];
    assign state_o  = state_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (cs_act) state_d = ST_HEADER;
            ST_HEADER: begin
                if (!cs_act)                    state_d = ST_IDLE;
                else if (sclk_rise && hdr_last) state_d = chip_hit ? ST_PAYLOAD : ST_IGNORE;
            end
            ST_PAYLOAD: begin
                if (!cs_act)                    state_d = ST_IDLE;
                else if (sclk_rise && pay_last) state_d = ST_HEADER;
            end
            ST_IGNORE:  if (!cs_act) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            hdr_sr  <= '0;
            pay_sr  <= '0;
            so_sr   <= '0;
            rw_q    <= 1'b0;
            reg_q   <= '0;
            so      <= 1'b0;
            wr_stb  <= 1'b0;
            wr_dc   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_stb <= 1'b0;
            if (!cs_act) begin
                cnt_q <= '0;
                so    <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_HEADER: begin
                        if (sclk_rise) begin
                            hdr_sr <= hdr_full[HDR_W-2:0];
                            if (hdr_last) begin
                                cnt_q <= '0;
                                rw_q  <= hdr_full[HDR_W-1];
                                reg_q <= hdr_full[REG_AW:1];
                                so_sr <= rd_data;
                            end else begin
                                cnt_q <= cnt_q + 1'b1;
                            end
                        end else if (sclk_fall) begin
                            so <= 1'b0;
                        end
                    end
                    ST_PAYLOAD: begin
                        if (sclk_rise) begin
                            pay_sr <= pay_full[DATA_W-1:0];
                            if (pay_last) begin
                                cnt_q <= '0;
                                if (!rw_q) begin
                                    wr_stb  <= 1'b1;
                                    wr_dc   <= pay_full[DATA_W];
                                    wr_addr <= reg_q;
                                    wr_data <= pay_full[DATA_W-1:0];
                                end
                            end else begin
                                cnt_q <= cnt_q + 1'b1;
                            end
                        end else if (sclk_fall) begin
                            if (rw_q && cnt_q != '0) begin
                                so    <= so_sr[DATA_W-1];
                                so_sr <= {so_sr[DATA_W-2:0], 1'b0};
                            end else begin
                                so <= 1'b0;
                            end
                        end
                    end
                    default: begin
                        cnt_q <= '0;
                        if (sclk_fall) so <= 1'b0;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/mdspi_regs.sv
`timescale 1ns/1ps
module mdspi_regs
    import mdspi_pkg::*;
#(
    parameter int REG_AW = 2,
    parameter int DATA_W = 24
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_stb,
    input  logic                          wr_dc,
    input  logic [REG_AW-1:0]             wr_addr,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic [REG_AW-1:0]             rd_addr,
    output logic [DATA_W-1:0]             rd_data,
    output logic [(1<<REG_AW)*DATA_W-1:0] cfg_regs,
    output logic                          locked,
    output logic                          cmd_valid,
    output logic [DATA_W-1:0]             cmd_data
);
    localparam int REG_CNT  = 1 << REG_AW;
    localparam int LOCK_IDX = REG_CNT - 1;

    logic [DATA_W-1:0] reg_vec [REG_CNT];
    logic              unlock_wr, wr_ok;

    assign locked    = (reg_vec[LOCK_IDX][1:0] == LOCK_CODE);
    assign unlock_wr = (wr_addr == REG_AW'(LOCK_IDX)) && (wr_data[1:0] != LOCK_CODE);
    assign wr_ok     = wr_stb && wr_dc && (!locked || unlock_wr);
    assign rd_data   = reg_vec[rd_addr];

    for (genvar i = 0; i < REG_CNT; i++) begin : g_reg
        logic [DATA_W-1:0] r_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                r_q <= '0;
            else if (wr_ok && wr_addr == REG_AW'(i))   r_q <= wr_data;
        end
        assign reg_vec[i]                    = r_q;
        assign cfg_regs[i*DATA_W +: DATA_W]  = r_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0;
            cmd_data  <= '0;
        end else begin
            cmd_valid <= wr_stb && !wr_dc && !locked;
            if (wr_stb && !wr_dc && !locked) cmd_data <= wr_data;
        end
    end
endmodule

// File: rtl/mdspi_regif.sv
`timescale 1ns/1ps
module mdspi_regif
    import mdspi_pkg::*;
#(
    parameter int CHIP_W = 1,
    parameter int REG_AW = 2,
    parameter int DATA_W = 24
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          spi_sclk,
    input  logic                          spi_cs_n,
    input  logic                          spi_mosi,
    output logic                          spi_miso,
    input  logic [CHIP_W-1:0]             chip_id,
    output logic [(1<<REG_AW)*DATA_W-1:0] cfg_regs,
    output logic                          locked,
    output logic                          cmd_valid,
    output logic [DATA_W-1:0]             cmd_data
);
    logic [2:0]        pins_s;
    logic              sclk_d;
    logic              cs_act, sclk_rise, sclk_fall;
    logic              wr_stb, wr_dc;
    logic [REG_AW-1:0] wr_addr, rd_addr;
    logic [DATA_W-1:0] wr_data, rd_data;
    frm_state_e        frm_state;

    mdspi_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({spi_cs_n, spi_sclk, spi_mosi}),
        .q_out (pins_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= pins_s[1];
    end

    assign cs_act    = ~pins_s[2];
    assign sclk_rise =  pins_s[1] & ~sclk_d;
    assign sclk_fall = ~pins_s[1] &  sclk_d;

    mdspi_frame #(.CHIP_W(CHIP_W), .REG_AW(REG_AW), .DATA_W(DATA_W)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_act    (cs_act),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .si        (pins_s[0]),
        .chip_id   (chip_id),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .wr_stb    (wr_stb),
        .wr_dc     (wr_dc),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .so        (spi_miso),
        .state_o   (frm_state)
    );

    mdspi_regs #(.REG_AW(REG_AW), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (wr_stb),
        .wr_dc     (wr_dc),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .cfg_regs  (cfg_regs),
        .locked    (locked),
        .cmd_valid (cmd_valid),
        .cmd_data  (cmd_data)
    );
endmodule

// File: rtl/mdspi_chk.sv
`timescale 1ns/1ps
module mdspi_chk
    import mdspi_pkg::*;
#(
    parameter int REG_AW = 2,
    parameter int DATA_W = 24
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          cs_act,
    input logic                          sclk_fall,
    input logic                          so,
    input frm_state_e                    state,
    input logic                          wr_stb,
    input logic                          wr_dc,
    input logic [REG_AW-1:0]             wr_addr,
    input logic                          locked,
    input logic [(1<<REG_AW)*DATA_W-1:0] cfg_regs,
    input logic                          cmd_valid
);
    localparam logic [REG_AW-1:0] LOCK_ADDR = REG_AW'((1 << REG_AW) - 1);

    AST_IGNORE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IGNORE |-> !so && !wr_stb); // R3

    AST_SO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(so) |-> $past(sclk_fall) || $past(!cs_act)); // R5

    AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid); // R9

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        locked && !(wr_stb && wr_dc && wr_addr == LOCK_ADDR) |=> locked && $stable(cfg_regs)); // R6

    AST_NO_CMD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> !cmd_valid); // R6
endmodule

bind mdspi_regif mdspi_chk #(.REG_AW(REG_AW), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_act    (cs_act),
    .sclk_fall (sclk_fall),
    .so        (spi_miso),
    .state     (frm_state),
    .wr_stb    (wr_stb),
    .wr_dc     (wr_dc),
    .wr_addr   (wr_addr),
    .locked    (locked),
    .cfg_regs  (cfg_regs),
    .cmd_valid (cmd_valid)
);

// File: tb/mdspi_regif_test.sv
`timescale 1ns/1ps
module mdspi_regif_test;
    localparam logic [0:0] MY_ID = 1'b1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_sclk = 1'b0;
    logic        spi_cs_n = 1'b1;
    logic        spi_mosi = 1'b0;
    logic        spi_miso;
    logic [95:0] cfg_regs;
    logic        locked;
    logic        cmd_valid;
    logic [23:0] cmd_data;

    mdspi_regif uut (
        .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .chip_id(MY_ID),
        .cfg_regs(cfg_regs), .locked(locked), .cmd_valid(cmd_valid), .cmd_data(cmd_data)
    );

    always #2 clk = ~clk;

    int          vectors = 0;
    int          miscompares = 0;
    int          settle = 0;
    bit          started = 0;
    bit          done = 0;
    string       req_tag = "R1";
    logic [23:0] m_reg [4];
    logic        m_so = 1'b0;
    bit          m_deaf = 0;
    int          exp_cmds = 0;
    logic [23:0] exp_cmd_data = '0;
    int          cmd_seen = 0;
    logic [23:0] cmd_last = '0;

    function automatic logic m_locked();
        return m_reg[3][1:0] == 2'b11;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) if (cmd_valid) begin
        cmd_seen++;
        cmd_last = cmd_data;
    end

    always @(negedge clk) begin
        settle++;
        if (started && !done && settle >= 5) begin
            for (int i = 0; i < 4; i++) chk(req_tag, 32'(cfg_regs[i*24 +: 24]), 32'(m_reg[i]), "register");
            chk(req_tag, 32'(spi_miso), 32'(m_so), "miso");
            chk(req_tag, 32'(locked), 32'(m_locked()), "locked");
        end
    end

    task automatic hold(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic drive(input logic s, input logic c, input logic d, input logic eso);
        @(posedge clk);
        #1;
        spi_sclk = s;
        spi_cs_n = c;
        spi_mosi = d;
        m_so     = eso;
        settle   = 0;
    endtask

    task automatic cs_begin();
        drive(1'b0, 1'b0, 1'b0, 1'b0);
        hold(7);
    endtask

    task automatic cs_end();
        drive(1'b0, 1'b0, 1'b0, 1'b0);
        hold(7);
        drive(1'b0, 1'b1, 1'b0, 1'b0);
        m_deaf = 0;
        hold(9);
    endtask

    // nb < 30 sends a truncated frame
    task automatic frame(input logic rw, input logic chip, input logic [1:0] addr, input logic dead,
                         input logic dc, input logic [23:0] data, input int nb, output logic [23:0] rd);
        logic [29:0] bits;
        logic [23:0] snap;
        bit          hit, rd_on;
        bits  = {rw, chip, addr, dead, dc, data};
        hit   = !m_deaf && (chip == MY_ID);
        rd_on = hit && rw;
        snap  = m_reg[addr];
        rd    = '0;
        for (int k = 0; k < nb; k++) begin
            logic b, eso;
            b   = bits[29-k];
            eso = (rd_on && k >= 6) ? snap[29-k] : 1'b0;
            drive(1'b0, 1'b0, b, eso);
            hold(7);
            if (k >= 6) rd[29-k] = spi_miso;
            drive(1'b1, 1'b0, b, m_so);
            if (k == 4 && chip != MY_ID) m_deaf = 1;
            if (k == 29 && hit && !rw) begin
                if (dc) begin
                    if (!m_locked() || (addr == 2'd3 && data[1:0] != 2'b11)) m_reg[addr] = data;
                end else if (!m_locked()) begin
                    exp_cmds++;
                    exp_cmd_data = data;
                end
            end
            hold(7);
        end
    endtask

    task automatic wr1(input logic [1:0] addr, input logic [23:0] data);
        logic [23:0] r;
        cs_begin();
        frame(1'b0, MY_ID, addr, 1'b0, 1'b1, data, 30, r);
        cs_end();
    endtask

    task automatic rd1(input logic [1:0] addr, output logic [23:0] r);
        cs_begin();
        frame(1'b1, MY_ID, addr, 1'b0, 1'b0, 24'h0, 30, r);
        cs_end();
    endtask

    initial begin
        #(4 * 100000);
        $display("FAIL watchdog: actual timeout expected completion");
        miscompares++;
        vectors++;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [23:0] r;
        for (int i = 0; i < 4; i++) m_reg[i] = '0;
        hold(5);
        #1 rst_n = 1'b1;
        hold(4);
        #1;
        // R1 reset state
        chk("R1", 32'(cfg_regs), 32'h0, "regs low");
        chk("R1", 32'(cfg_regs[95:32]), 32'h0, "regs high");
        chk("R1", 32'(spi_miso), 32'h0, "miso");
        chk("R1", 32'(locked), 32'h0, "locked");
        chk("R1", 32'(cmd_valid), 32'h0, "cmd_valid");
        started = 1;

        req_tag = "R2";
        wr1(2'd0, 24'hA5C3F0);
        wr1(2'd1, 24'h0F1E2D);
        wr1(2'd2, 24'h800001);

        req_tag = "R5";
        rd1(2'd0, r);
        chk("R5", 32'(r), 32'h00A5C3F0, "read reg0");
        rd1(2'd2, r);
        chk("R5", 32'(r), 32'h00800001, "read reg2");

        req_tag = "R4";
        cs_begin();
        frame(1'b0, MY_ID, 2'd1, 1'b0, 1'b1, 24'h123456, 30, r);
        frame(1'b0, MY_ID, 2'd2, 1'b0, 1'b1, 24'hFEDCBA, 30, r);
        frame(1'b1, MY_ID, 2'd1, 1'b0, 1'b0, 24'h000000, 30, r);
        chk("R4", 32'(r), 32'h00123456, "back-to-back read");
        cs_end();

        req_tag = "R10";
        cs_begin();
        frame(1'b0, MY_ID, 2'd0, 1'b1, 1'b1, 24'h5A5A5A, 30, r);
        cs_end();
        chk("R10", 32'(cfg_regs[23:0]), 32'h005A5A5A, "spare bit set");

        req_tag = "R9";
        cs_begin();
        frame(1'b0, MY_ID, 2'd2, 1'b0, 1'b0, 24'hC0FFEE, 30, r);
        cs_end();
        chk("R9", 32'(cmd_seen), 32'(exp_cmds), "command count");
        chk("R9", 32'(cmd_last), 32'(exp_cmd_data), "command word");

        req_tag = "R3";
        cs_begin();
        frame(1'b0, ~MY_ID, 2'd0, 1'b0, 1'b1, 24'h111111, 30, r);
        frame(1'b0, MY_ID, 2'd1, 1'b0, 1'b1, 24'h222222, 30, r);
        frame(1'b1, MY_ID, 2'd2, 1'b0, 1'b0, 24'h000000, 30, r);
        chk("R3", 32'(r), 32'h0, "miso after mismatch");
        frame(1'b0, MY_ID, 2'd0, 1'b0, 1'b0, 24'h333333, 30, r);
        cs_end();
        chk("R3", 32'(cmd_seen), 32'(exp_cmds), "no command after mismatch");
        rd1(2'd2, r);
        chk("R3", 32'(r), 32'h00FEDCBA, "read after reselect");

        req_tag = "R8";
        cs_begin();
        frame(1'b0, MY_ID, 2'd0, 1'b0, 1'b1, 24'h777777, 17, r);
        cs_end();
        cs_begin();
        frame(1'b0, MY_ID, 2'd1, 1'b0, 1'b1, 24'h0BEEF0, 30, r);
        cs_end();
        chk("R8", 32'(cfg_regs[23:0]), 32'h005A5A5A, "aborted frame dropped");
        chk("R8", 32'(cfg_regs[47:24]), 32'h000BEEF0, "next frame decoded");

        req_tag = "R7";
        wr1(2'd3, 24'h000001);
        wr1(2'd0, 24'h010101);
        wr1(2'd3, 24'h000002);
        wr1(2'd0, 24'h020202);
        wr1(2'd3, 24'hABCD00);
        wr1(2'd0, 24'h030303);
        chk("R7", 32'(cfg_regs[23:0]), 32'h00030303, "writes open with code 00");

        req_tag = "R6";
        wr1(2'd3, 24'h000003);
        chk("R6", 32'(locked), 32'h1, "locked set");
        wr1(2'd0, 24'h999999);
        wr1(2'd3, 24'h0000FF);
        cs_begin();
        frame(1'b0, MY_ID, 2'd1, 1'b0, 1'b0, 24'h444444, 30, r);
        cs_end();
        chk("R6", 32'(cmd_seen), 32'(exp_cmds), "command blocked");
        chk("R6", 32'(cfg_regs[95:72]), 32'h00000003, "relock write ignored");

        req_tag = "R11";
        rd1(2'd0, r);
        chk("R11", 32'(r), 32'h00030303, "read while locked");

        req_tag = "R6";
        wr1(2'd3, 24'h123456);
        chk("R6", 32'(locked), 32'h0, "unlock");
        chk("R6", 32'(cfg_regs[95:72]), 32'h00123456, "unlock word stored");
        wr1(2'd0, 24'h0A0B0C);
        chk("R6", 32'(cfg_regs[23:0]), 32'h000A0B0C, "write after unlock");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule